// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is a width-parameterised register, eight bits wide by default. On each rising clock edge it does one of four things: keeps its contents, shifts toward the high end, shifts toward the low end, or loads a word from a shared parallel bus. That same bus also carries the register contents outward. The bidirectional pad is modelled as three signals: an input vector, an output vector that always carries the register contents, and a single bus-drive enable. Pad buffers are placed outside the block. The bus is driven only when both active-low output enables are low and the block is not loading. A load cycle always releases the bus, so that another agent can drive it.

Reset is active low, synchronous, and takes priority over every mode. Two dedicated serial taps expose the lowest and highest register bits at all times, and neither the enables nor the mode affects them. Several blocks can be chained: one block's high tap feeds the next block's low serial input, and that block's low tap feeds back into the first block's high serial input. The chain then acts as one wider shift register in both directions. The block has no streaming data path, so every pin is a plain level signal sampled at the clock edge.

Top module: `ubus_shreg`

## Requirements
- R1: State changes only at a rising clock edge; input changes between edges leave `bus_out`, `tap_lo` and `tap_hi` unchanged.
- R2: With `mode_sel` = 2'b00 (hold) and `rst_n` high, the register keeps its value across the edge.
- R3: When `rst_n` is low at a rising edge, every register bit becomes 0 after that edge, whatever `mode_sel`, the serial inputs or the bus hold.
- R4: With `mode_sel` = 2'b01 (shift up), `ser_in_lo` enters bit 0 and each bit n moves to bit n+1; the old top bit is dropped.
- R5: With `mode_sel` = 2'b10 (shift down), `ser_in_hi` enters the top bit and each bit n moves to bit n-1; the old bit 0 is dropped.
- R6: With `mode_sel` = 2'b11 (load), register bit n takes `bus_in[n]` at the edge.
- R7: `bus_oe` is 1 exactly when `oe_a_n` and `oe_b_n` are both 0 and `mode_sel` is not 2'b11; it follows these inputs combinationally.
- R8: With `mode_sel` = 2'b11, `bus_oe` is 0 whatever the enables and the reset input.
- R9: `tap_lo` equals register bit 0 and `tap_hi` equals the top register bit at all times, independent of the enables and the mode.
- R10: Two blocks chained as described above behave as one 16-bit register in both shift directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low, highest priority |
| mode_sel | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 parallel load |
| oe_a_n | input | 1 | First bus output enable, active low |
| oe_b_n | input | 1 | Second bus output enable, active low |
| ser_in_lo | input | 1 | Serial bit entering bit 0 on shift up |
| ser_in_hi | input | 1 | Serial bit entering the top bit on shift down |
| bus_in | input | WIDTH | Value seen on the shared bus (parallel load source) |
| bus_out | output | WIDTH | Register contents to drive onto the bus |
| bus_oe | output | 1 | Drive enable for the bus pads |
| tap_lo | output | 1 | Always-on copy of register bit 0 |
| tap_hi | output | 1 | Always-on copy of the top register bit |

## Verification
The bench sweeps all sixteen mode and enable combinations. A decoder that let the enables override the load release would drive the bus while it is needed as an input. One that ignored the second enable would drive the bus when only one enable is low. The bench asserts reset together with load and together with a shift. A design that gave a mode priority over reset would then capture bus or serial data instead of clearing. A full 16-bit shift through two chained blocks in each direction checks the taps. Crossed neighbour wiring, or a tap taken from the wrong end, shows up as a scrambled word. Changing the load inputs between edges checks that nothing in the block is level-sensitive.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } shreg_mode_e;

  typedef struct packed {
    logic load;
    logic up;
    logic down;
  } shreg_ctl_t;

endpackage

// File: rtl/shreg_mode_dec.sv
module shreg_mode_dec
  import shreg_pkg::*;
(
  input  logic [1:0] mode_sel,
  output shreg_ctl_t ctl
);

  shreg_mode_e mode;

  always_comb begin
    mode     = shreg_mode_e'(mode_sel);
    ctl      = '0;
    unique case (mode)
      MODE_UP:   ctl.up   = 1'b1;
      MODE_DOWN: ctl.down = 1'b1;
      MODE_LOAD: ctl.load = 1'b1;
      default:   ctl      = '0;
    endcase
  end

endmodule

// File: rtl/shreg_bus_gate.sv
module shreg_bus_gate (
  input  logic oe_a_n,
  input  logic oe_b_n,
  input  logic load,
  output logic bus_oe
);

  // The bus is released while loading so that it can serve as the source.
  always_comb begin
    bus_oe = ~oe_a_n & ~oe_b_n & ~load;
  end

endmodule

// File: rtl/shreg_cell.sv
module shreg_cell
  import shreg_pkg::*;
(
  input  logic       clk,
  input  logic       clr,
  input  shreg_ctl_t ctl,
  input  logic       from_below,
  input  logic       from_above,
  input  logic       par_in,
  output logic       q
);

  logic d;

  always_comb begin
    d = q;
    if (clr)           d = 1'b0;
    else if (ctl.load) d = par_in;
    else if (ctl.up)   d = from_below;
    else if (ctl.down) d = from_above;
  end

  always_ff @(posedge clk) begin
    q <= d;
  end

endmodule

// File: rtl/ubus_shreg.sv
module ubus_shreg
  import shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic             ser_in_lo,
  input  logic             ser_in_hi,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_oe,
  output logic             tap_lo,
  output logic             tap_hi
);

  localparam int TOP = WIDTH - 1;

  shreg_ctl_t       ctl;
  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] below;
  logic [WIDTH-1:0] above;

  shreg_mode_dec dec_i (
    .mode_sel (mode_sel),
    .ctl      (ctl)
  );

  shreg_bus_gate gate_i (
    .oe_a_n (oe_a_n),
    .oe_b_n (oe_b_n),
    .load   (ctl.load),
    .bus_oe (bus_oe)
  );

  genvar n;
  generate
    for (n = 0; n < WIDTH; n++) begin : g_bit
      if (n == 0) begin : g_lo
        assign below[n] = ser_in_lo;
      end else begin : g_mid_lo
        assign below[n] = q[n-1];
      end
      if (n == TOP) begin : g_hi
        assign above[n] = ser_in_hi;
      end else begin : g_mid_hi
        assign above[n] = q[n+1];
      end
      shreg_cell cell_i (
        .clk        (clk),
        .clr        (~rst_n),
        .ctl        (ctl),
        .from_below (below[n]),
        .from_above (above[n]),
        .par_in     (bus_in[n]),
        .q          (q[n])
      );
    end
  endgenerate

  assign bus_out = q;
  assign tap_lo  = q[0];
  assign tap_hi  = q[TOP];

endmodule

// File: rtl/ubus_shreg_chk.sv
module ubus_shreg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_sel,
  input logic             oe_a_n,
  input logic             oe_b_n,
  input logic             ser_in_lo,
  input logic             ser_in_hi,
  input logic [WIDTH-1:0] bus_in,
  input logic [WIDTH-1:0] bus_out,
  input logic             bus_oe,
  input logic             tap_lo,
  input logic             tap_hi
);

  logic seen_edge = 1'b0;
  always_ff @(posedge clk) seen_edge <= 1'b1;

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!seen_edge)
    !rst_n |=> bus_out == '0); // R3

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b00 |=> $stable(bus_out)); // R2

  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b01 |=> bus_out == {$past(bus_out[WIDTH-2:0]), $past(ser_in_lo)}); // R4

  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b10 |=> bus_out == {$past(ser_in_hi), $past(bus_out[WIDTH-1:1])}); // R5

  AST_LOAD_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b11 |=> bus_out == $past(bus_in)); // R6

  AST_BUS_DRIVEN: assert property (@(posedge clk) disable iff (!seen_edge)
    (!oe_a_n && !oe_b_n && mode_sel != 2'b11) |-> bus_oe); // R7

  AST_BUS_OFF_BY_ENABLE: assert property (@(posedge clk) disable iff (!seen_edge)
    (oe_a_n || oe_b_n) |-> !bus_oe); // R7

  AST_LOAD_RELEASES: assert property (@(posedge clk) disable iff (!seen_edge)
    mode_sel == 2'b11 |-> !bus_oe); // R8

  AST_TAPS_FOLLOW: assert property (@(posedge clk) disable iff (!seen_edge)
    tap_lo == bus_out[0] && tap_hi == bus_out[WIDTH-1]); // R9

endmodule

bind ubus_shreg ubus_shreg_chk #(.WIDTH(WIDTH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_sel  (mode_sel),
  .oe_a_n    (oe_a_n),
  .oe_b_n    (oe_b_n),
  .ser_in_lo (ser_in_lo),
  .ser_in_hi (ser_in_hi),
  .bus_in    (bus_in),
  .bus_out   (bus_out),
  .bus_oe    (bus_oe),
  .tap_lo    (tap_lo),
  .tap_hi    (tap_hi)
);

// File: tb/ubus_shreg_tb_top.sv
module ubus_shreg_tb_top;

  localparam int W = 8;
  localparam int WDOG_CYCLES = 20000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b1;
  logic [1:0]    mode = 2'b00;
  logic          ea_n = 1'b1, eb_n = 1'b1;
  logic          sin_up = 1'b0, sin_down = 1'b0;
  logic [15:0]   din = '0;

  logic [W-1:0]  lo_bus, hi_bus;
  logic          lo_oe, hi_oe;
  logic          lo_tlo, lo_thi, hi_tlo, hi_thi;

  ubus_shreg #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode), .oe_a_n(ea_n), .oe_b_n(eb_n),
    .ser_in_lo(sin_up), .ser_in_hi(hi_tlo), .bus_in(din[7:0]),
    .bus_out(lo_bus), .bus_oe(lo_oe), .tap_lo(lo_tlo), .tap_hi(lo_thi)
  );

  ubus_shreg #(.WIDTH(W)) dut_hi_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode), .oe_a_n(ea_n), .oe_b_n(eb_n),
    .ser_in_lo(lo_thi), .ser_in_hi(sin_down), .bus_in(din[15:8]),
    .bus_out(hi_bus), .bus_oe(hi_oe), .tap_lo(hi_tlo), .tap_hi(hi_thi)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic done = 1'b0;

  logic [15:0] ref_q = '0;
  logic [16:0] exp_q[$];
  string       tag_q[$];

  task automatic compare(input logic [16:0] e, input string tag);
    logic [15:0] bus;
    logic        ok;
    bus = {hi_bus, lo_bus};
    ok = (bus == e[15:0]) && (lo_oe == e[16]) && (hi_oe == e[16]) &&
         (lo_tlo == e[0]) && (lo_thi == e[7]) && (hi_tlo == e[8]) && (hi_thi == e[15]);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: bus=%h oe=%b%b taps=%b%b%b%b, expected bus=%h oe=%b taps=%b%b%b%b",
               tag, bus, hi_oe, lo_oe, hi_thi, hi_tlo, lo_thi, lo_tlo,
               e[15:0], e[16], e[15], e[8], e[7], e[0]);
    end
  endtask

  // Driver: set inputs after a falling edge, push the expectation for the next rising edge.
  task automatic apply(input logic r, input logic [1:0] m, input logic a, input logic b,
                       input logic su, input logic sd, input logic [15:0] d, input string tag);
    @(negedge clk);
    rst_n = r; mode = m; ea_n = a; eb_n = b; sin_up = su; sin_down = sd; din = d;
    if (!r)             ref_q = '0;
    else if (m == 2'b01) ref_q = {ref_q[14:0], su};
    else if (m == 2'b10) ref_q = {sd, ref_q[15:1]};
    else if (m == 2'b11) ref_q = d;
    exp_q.push_back({(!a && !b && m != 2'b11), ref_q});
    tag_q.push_back(tag);
  endtask

  // Monitor: compare just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  // R1: load inputs change mid-cycle; state must not move until an edge.
  task automatic mid_cycle_check();
    @(negedge clk);
    rst_n = 1'b0; mode = 2'b11; din = ~ref_q; sin_up = 1'b1; sin_down = 1'b1;
    #1;
    compare({1'b0, ref_q}, "R1");
    rst_n = 1'b1; mode = 2'b00; ea_n = 1'b0; eb_n = 1'b0;
    exp_q.push_back({1'b1, ref_q});
    tag_q.push_back("R1/R2");
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] pat;
    apply(1'b0, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 16'hFFFF, "R3/R7 reset state");
    apply(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, "R2/R7");
    apply(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'hA5C3, "R6/R8");
    apply(1'b1, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0F0F, "R2/R7/R9");
    apply(1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0F0F, "R2/R7/R9");
    pat = 16'h3C96;
    for (int i = 0; i < 16; i++)
      apply(1'b1, 2'b01, 1'b0, 1'b0, pat[i], 1'b0, 16'h0000, "R4/R10 cascade up");
    apply(1'b1, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 16'h8001, "R6/R8");
    pat = 16'hF00D;
    for (int i = 0; i < 16; i++)
      apply(1'b1, 2'b10, 1'b0, 1'b0, 1'b0, pat[i], 16'h0000, "R5/R10 cascade down");
    for (int m = 0; m < 4; m++)
      for (int e = 0; e < 4; e++)
        apply(1'b1, 2'(m), e[1], e[0], e[0], e[1], 16'h1234 + 16'(m * 16'h1111 + e),
              "R7/R8/R9 sweep");
    mid_cycle_check();
    apply(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF, "R6");
    apply(1'b0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 16'hFFFF, "R3/R8 reset over load");
    apply(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'hC3C3, "R6");
    apply(1'b0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 16'hFFFF, "R3/R7 reset over shift");
    apply(1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, "R2/R7");
    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule